// File: doc/BRIEF.md
# Capture/Compare Timer with Split Interrupt Enables

A 16-bit up-counter that two capture channels and two compare channels watch. Each capture channel latches the counter value on a programmable edge of its input. Each compare channel raises a flag when the counter reaches its compare value. A PWM mode turns the second compare value into the period: the counter reloads on that match, and the output drops on the first compare match. A small divider sets how often the counter advances.

The block has two interrupt request lines: one for capture events and one for compare events. Each line has a type-wide enable. While the type-wide enable is set, a flag on either channel raises the line. While it is clear, each channel's flag raises the line only if that channel's own enable bit is set. Software drives the block through a word-wide register bus with one write port and a combinational read port. It clears flags by writing zeros to them.

Top module: `ccti_timer`

## Requirements
- R1: While CTRL (address 0) bit 0 is 1, the counter (read and loaded at address 7) increases by one every DIV+1 clocks, where DIV is the register at address 8. It wraps from 0xFFFF to 0x0000 outside PWM mode. While bit 0 is 0, the counter holds. A bus write to address 7 loads the counter.
- R2: For capture channel k (input cap_in[k], capture register at address 5+k), CTRL bit 4+k selects the edge: 1 = rising, 0 = falling. The selected edge stores the counter value and sets STAT (address 2) bit k. The other edge changes nothing.
- R3: Outside PWM mode, a counter advance taken while the counter equals CMP1 (address 3) sets STAT bit 2. One taken while it equals CMP2 (address 4) sets STAT bit 3.
- R4: A write to STAT clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. A hardware set in the same cycle wins over the clear.
- R5: IEN (address 1) holds the per-channel enables: bit 7 capture 1, bit 6 compare 1, bit 5 capture 2, bit 4 compare 2.
- R6: While the type-wide enable is 1 (CTRL bit 2 for capture, CTRL bit 3 for compare), the matching request is high whenever either flag of that type is set, whatever the IEN bits are.
- R7: While the type-wide enable is 0, the request is high only when some flag of that type is set and that channel's IEN bit is also set.
- R8: With the type-wide enable and both IEN bits of a type at 0, that request stays low whatever the flags are.
- R9: In PWM mode (CTRL bit 1 = 1), hardware never sets STAT bit 2.
- R10: In PWM mode, every counter advance taken at CMP2 sets STAT bit 3, reloads the counter to 0 and drives pwm_out high.
- R11: In PWM mode, an advance taken at CMP1 drives pwm_out low, unless that same advance is also at CMP2, where the reload wins. With divider 0 and CMP1 < CMP2, the output is high for CMP1+1 clocks of every CMP2+1. Outside PWM mode, pwm_out is low.
- R12: After reset, every register, both requests and pwm_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| cap_in | input | 2 | Capture inputs, synchronous to clk |
| cap_irq | output | 1 | Capture interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions assume that the capture inputs are already synchronous to clk. They also assume that a compare register or the divider changes only while the counter is stopped, so each match value is seen for exactly one counter advance. The stimulus changes cap_in and the bus on the falling clock edge. It stops the counter before it reprograms the compare values, the divider or the mode. It loads the counter only while the counter is stopped. This keeps every expected count and every PWM duty an exact function of the programmed values.

// File: rtl/ccti_pkg.sv
package ccti_pkg;

    // Register addresses.
    typedef enum logic [3:0] {
        A_CTRL  = 4'd0,
        A_IEN   = 4'd1,
        A_STAT  = 4'd2,
        A_CMP1  = 4'd3,
        A_CMP2  = 4'd4,
        A_CAP1  = 4'd5,
        A_CAP2  = 4'd6,
        A_COUNT = 4'd7,
        A_DIV   = 4'd8
    } reg_addr_e;

    // CTRL bit positions.
    localparam int C_RUN    = 0;
    localparam int C_PWM    = 1;
    localparam int C_CAPALL = 2;
    localparam int C_CMPALL = 3;
    localparam int C_EDGE1  = 4;
    localparam int C_EDGE2  = 5;
    localparam int CTRL_W   = 6;

    // Stored per-channel enables: bus bits 7..4 land in stored bits 3..0.
    localparam int E_CAP1 = 3;
    localparam int E_CMP1 = 2;
    localparam int E_CAP2 = 1;
    localparam int E_CMP2 = 0;
    localparam int IEN_LSB = 4;

    // STAT flag positions.
    localparam int S_CAP1 = 0;
    localparam int S_CAP2 = 1;
    localparam int S_CMP1 = 2;
    localparam int S_CMP2 = 3;
    localparam int NFLAG  = 4;

endpackage

// File: rtl/ccti_prescaler.sv
module ccti_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pre_d, pre_q;

    always_comb begin
        tick = run && (pre_q == div);
        if (!run || tick) pre_d = '0;
        else              pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (pre_q == '0)); // R1
endmodule

// File: rtl/ccti_capture.sv
module ccti_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             rise_sel,
    input  logic [CNT_W-1:0] count,
    output logic             hit,
    output logic [CNT_W-1:0] cap_val
);
    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cap;
    } cs_t;

    cs_t cs_d, cs_q;

    always_comb begin
        hit      = rise_sel ? (sig_in & ~cs_q.prev) : (~sig_in & cs_q.prev);
        cs_d     = cs_q;
        cs_d.prev = sig_in;
        if (hit) cs_d.cap = count;
        cap_val  = cs_q.cap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cap_val == $past(count))); // R2
    AST_CAPTURE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |=> $stable(cap_val)); // R2
endmodule

// File: rtl/ccti_irq_merge.sv
module ccti_irq_merge (
    input  logic       all_en,
    input  logic [1:0] ch_en,
    input  logic [1:0] flag,
    output logic       irq
);
    always_comb begin
        if (all_en) irq = |flag;
        else        irq = |(flag & ch_en);
    end
endmodule

// File: rtl/ccti_timer.sv
module ccti_timer
    import ccti_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic [1:0]       cap_in,
    output logic             cap_irq,
    output logic             cmp_irq,
    output logic             pwm_out
);
    localparam int NCH = 2;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [3:0]        ien;
        logic [NFLAG-1:0]  stat;
        logic [CNT_W-1:0]  cmp1;
        logic [CNT_W-1:0]  cmp2;
        logic [CNT_W-1:0]  cnt;
        logic [DIV_W-1:0]  div;
        logic              pwm_o;
    } tm_t;

    tm_t              st_d, st_q;
    logic             tick;
    logic [NCH-1:0]   cap_hit;
    logic [CNT_W-1:0] cap_val [NCH];
    logic             cmp1_hit, cmp2_hit, pwm_m;
    logic [NFLAG-1:0] set_v, clr_mask;
    reg_addr_e        sel;

    ccti_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.ctrl[C_RUN]),
        .div   (st_q.div),
        .tick  (tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_cap
        ccti_capture #(.CNT_W(CNT_W)) u_cap (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig_in   (cap_in[i]),
            .rise_sel (st_q.ctrl[C_EDGE1+i]),
            .count    (st_q.cnt),
            .hit      (cap_hit[i]),
            .cap_val  (cap_val[i])
        );
    end

    ccti_irq_merge u_cap_irq (
        .all_en (st_q.ctrl[C_CAPALL]),
        .ch_en  ({st_q.ien[E_CAP2], st_q.ien[E_CAP1]}),
        .flag   ({st_q.stat[S_CAP2], st_q.stat[S_CAP1]}),
        .irq    (cap_irq)
    );

    ccti_irq_merge u_cmp_irq (
        .all_en (st_q.ctrl[C_CMPALL]),
        .ch_en  ({st_q.ien[E_CMP2], st_q.ien[E_CMP1]}),
        .flag   ({st_q.stat[S_CMP2], st_q.stat[S_CMP1]}),
        .irq    (cmp_irq)
    );

    always_comb begin
        st_d     = st_q;
        sel      = reg_addr_e'(addr);
        pwm_m    = st_q.ctrl[C_PWM];
        cmp1_hit = tick && (st_q.cnt == st_q.cmp1);
        cmp2_hit = tick && (st_q.cnt == st_q.cmp2);

        set_v            = '0;
        set_v[S_CAP1]    = cap_hit[0];
        set_v[S_CAP2]    = cap_hit[1];
        set_v[S_CMP1]    = cmp1_hit && !pwm_m;
        set_v[S_CMP2]    = cmp2_hit;

        // Counter advance, with reload on the period match in PWM mode.
        if (tick) begin
            if (pwm_m && cmp2_hit) st_d.cnt = '0;
            else                   st_d.cnt = st_q.cnt + 1'b1;
        end

        // PWM output: reload sets, first compare clears, reload wins a tie.
        if (pwm_m) begin
            if (cmp2_hit)      st_d.pwm_o = 1'b1;
            else if (cmp1_hit) st_d.pwm_o = 1'b0;
        end else begin
            st_d.pwm_o = 1'b0;
        end

        clr_mask = '1;
        if (wr_en) begin
            case (sel)
                A_CTRL:  st_d.ctrl = wdata[CTRL_W-1:0];
                A_IEN:   st_d.ien  = wdata[IEN_LSB+3:IEN_LSB];
                A_STAT:  clr_mask  = wdata[NFLAG-1:0];
                A_CMP1:  st_d.cmp1 = wdata;
                A_CMP2:  st_d.cmp2 = wdata;
                A_COUNT: st_d.cnt  = wdata;
                A_DIV:   st_d.div  = wdata[DIV_W-1:0];
                default: ;
            endcase
        end

        st_d.stat = (st_q.stat & clr_mask) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (sel)
            A_CTRL:  rdata = CNT_W'(st_q.ctrl);
            A_IEN:   rdata = CNT_W'({st_q.ien, 4'b0000});
            A_STAT:  rdata = CNT_W'(st_q.stat);
            A_CMP1:  rdata = st_q.cmp1;
            A_CMP2:  rdata = st_q.cmp2;
            A_CAP1:  rdata = cap_val[0];
            A_CAP2:  rdata = cap_val[1];
            A_COUNT: rdata = st_q.cnt;
            A_DIV:   rdata = CNT_W'(st_q.div);
            default: rdata = '0;
        endcase
    end

    assign pwm_out = st_q.pwm_o;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl[C_RUN] && !(wr_en && sel == A_COUNT)) |=> $stable(st_q.cnt)); // R1
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat[S_CMP2] && !(wr_en && sel == A_STAT)) |=> st_q.stat[S_CMP2]); // R4
    AST_CAP_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl[C_CAPALL] && (st_q.stat[S_CAP1] || st_q.stat[S_CAP2])) |-> cap_irq); // R6
    AST_CAP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl[C_CAPALL] && !st_q.ien[E_CAP1] && !st_q.stat[S_CAP2]) |-> !cap_irq); // R7
    AST_CMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl[C_CMPALL] && !st_q.ien[E_CMP1] && !st_q.ien[E_CMP2]) |-> !cmp_irq); // R8
    AST_PWM_CMP1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl[C_PWM] && !st_q.stat[S_CMP1]) |=> !st_q.stat[S_CMP1]); // R9
    AST_PWM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl[C_PWM] && tick && st_q.cnt == st_q.cmp2 && !(wr_en && sel == A_COUNT))
        |=> (st_q.cnt == '0 && pwm_out)); // R10
    AST_PWM_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl[C_PWM]) |=> !pwm_out); // R11
endmodule

// File: tb/ccti_timer_tb.sv
`timescale 1ns/1ps
module ccti_timer_tb;
    localparam logic [3:0] AD_CTRL = 4'd0, AD_IEN = 4'd1, AD_STAT = 4'd2, AD_CMP1 = 4'd3,
                           AD_CMP2 = 4'd4, AD_CAP1 = 4'd5, AD_CAP2 = 4'd6, AD_COUNT = 4'd7,
                           AD_DIV = 4'd8;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0, rdata;
    logic [1:0]  cap_in = '0;
    logic        cap_irq, cmp_irq, pwm_out;
    int          n_chk = 0, n_bad = 0;
    logic [15:0] rv;

    always #4 clk = ~clk;

    ccti_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_in(cap_in), .cap_irq(cap_irq), .cmp_irq(cmp_irq),
        .pwm_out(pwm_out)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic logic [15:0] mk_ctrl(input logic run, pwm, capall, cmpall, e1, e2);
        return {10'b0, e2, e1, cmpall, capall, pwm, run};
    endfunction

    function automatic logic exp_irq(input logic all_en, en_a, en_b, f_a, f_b);
        return all_en ? (f_a | f_b) : ((f_a & en_a) | (f_b & en_b));
    endfunction

    function automatic int exp_count(input int n, input int d);
        return n / (d + 1);
    endfunction

    function automatic int exp_high(input int c1, input int c2, input int periods);
        return (c1 < c2) ? periods * (c1 + 1) : periods * (c2 + 1);
    endfunction

    // Runs the counter for exactly n clocks from the current falling edge.
    task automatic run_for(input logic [15:0] base, input int n);
        wr(AD_CTRL, base | 16'h1);
        idle(n - 1);
        wr(AD_CTRL, base & ~16'h1);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    task automatic pwm_case(input int c1, input int c2);
        int highs, w;
        logic [15:0] base;
        base = mk_ctrl(0, 1, 0, 0, 1, 1);
        wr(AD_CTRL, base);
        wr(AD_CMP1, 16'(c1));
        wr(AD_CMP2, 16'(c2));
        wr(AD_COUNT, 16'h0);
        wr(AD_STAT, 16'h0);
        wr(AD_CTRL, base | 16'h1);
        idle(3 * (c2 + 1) + 2);
        highs = 0;
        w = 4 * (c2 + 1);
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
        chk(highs, exp_high(c1, c2, 4), $sformatf("R11 duty c1=%0d c2=%0d", c1, c2));
        wr(AD_CTRL, base);
        rd(AD_STAT, rv);
        chk(rv[2], 1'b0, "R9 compare-1 flag in PWM");
        chk(rv[3], 1'b1, "R10 compare-2 flag in PWM");
    endtask

    initial begin
        logic [15:0] v1, v2, base;
        void'($urandom(32'h5eed_0042));
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R12 reset state
        rd(AD_CTRL, rv);  chk(rv, 16'h0, "R12 CTRL");
        rd(AD_STAT, rv);  chk(rv, 16'h0, "R12 STAT");
        rd(AD_COUNT, rv); chk(rv, 16'h0, "R12 COUNT");
        rd(AD_CAP1, rv);  chk(rv, 16'h0, "R12 CAP1");
        chk({cap_irq, cmp_irq, pwm_out}, 3'b000, "R12 outputs");

        // R1 counting, divider, wrap, hold
        wr(AD_CMP1, 16'h8000); wr(AD_CMP2, 16'h8000);
        base = mk_ctrl(0, 0, 0, 0, 1, 1);
        run_for(base, 10);
        rd(AD_COUNT, rv); chk(rv, 16'd10, "R1 count div0");
        for (int it = 0; it < 8; it++) begin
            int d, n;
            d = $urandom_range(0, 3);
            n = $urandom_range(1, 40);
            wr(AD_DIV, 16'(d));
            wr(AD_COUNT, 16'h0);
            run_for(base, n);
            rd(AD_COUNT, rv);
            chk(rv, 16'(exp_count(n, d)), $sformatf("R1 count d=%0d n=%0d", d, n));
        end
        wr(AD_DIV, 16'h0);
        wr(AD_COUNT, 16'hFFFE);
        run_for(base, 3);
        rd(AD_COUNT, rv); chk(rv, 16'h0001, "R1 wrap");
        idle(5);
        rd(AD_COUNT, rv); chk(rv, 16'h0001, "R1 hold when stopped");

        // R2 capture edges: channel 1 rising, channel 2 falling
        wr(AD_CTRL, mk_ctrl(0, 0, 0, 0, 1, 0));
        for (int it = 0; it < 4; it++) begin
            v1 = 16'($urandom);
            v2 = 16'($urandom);
            wr(AD_COUNT, v1);
            wr(AD_STAT, 16'h0);
            cap_in[0] = 1'b1; idle(1);
            rd(AD_CAP1, rv); chk(rv, v1, "R2 rising capture ch1");
            rd(AD_STAT, rv); chk(rv[0], 1'b1, "R2 flag ch1");
            wr(AD_COUNT, ~v1);
            cap_in[0] = 1'b0; idle(1);
            rd(AD_CAP1, rv); chk(rv, v1, "R2 falling ignored ch1");
            cap_in[1] = 1'b1; idle(1);
            rd(AD_STAT, rv); chk(rv[1], 1'b0, "R2 rising ignored ch2");
            wr(AD_COUNT, v2);
            cap_in[1] = 1'b0; idle(1);
            rd(AD_CAP2, rv); chk(rv, v2, "R2 falling capture ch2");
            rd(AD_STAT, rv); chk(rv[1], 1'b1, "R2 flag ch2");
        end

        // R3 compare flags in normal mode
        wr(AD_CTRL, base);
        wr(AD_CMP1, 16'd4); wr(AD_CMP2, 16'd100);
        wr(AD_COUNT, 16'h0); wr(AD_STAT, 16'h0);
        run_for(base, 6);
        rd(AD_STAT, rv); chk(rv[3:2], 2'b01, "R3 only compare-1 reached");
        wr(AD_CMP2, 16'd7);
        run_for(base, 3);
        rd(AD_STAT, rv); chk(rv[3:2], 2'b11, "R3 compare-2 reached");

        // R4 clear semantics and set-over-clear priority
        wr(AD_STAT, 16'h0008);
        rd(AD_STAT, rv); chk(rv[3:0], 4'b1000, "R4 write 1 keeps, 0 clears");
        wr(AD_STAT, 16'h0);
        wr(AD_CMP1, 16'd5); wr(AD_CMP2, 16'h8000);
        wr(AD_COUNT, 16'h0);
        wr(AD_CTRL, base | 16'h1);
        idle(5);
        wr(AD_STAT, 16'h0);
        wr(AD_CTRL, base);
        rd(AD_STAT, rv); chk(rv[2], 1'b1, "R4 hardware set beats clear");
        wr(AD_STAT, 16'h0);
        rd(AD_STAT, rv); chk(rv[2], 1'b0, "R4 later clear");

        // R5..R8 interrupt enable scheme, random flag and enable patterns
        wr(AD_CMP1, 16'd2); wr(AD_CMP2, 16'd3);
        for (int it = 0; it < 24; it++) begin
            logic [3:0] keep, ie;
            logic gc, gm, ec, em;
            keep = 4'($urandom);
            ie   = 4'($urandom);
            gc   = 1'($urandom);
            gm   = 1'($urandom);
            if (it == 0) begin keep = 4'hF; ie = 4'h0; gc = 1'b0; gm = 1'b0; end
            if (it == 1) begin keep = 4'hF; ie = 4'h0; gc = 1'b1; gm = 1'b1; end
            wr(AD_CTRL, base);
            wr(AD_STAT, 16'h0);
            wr(AD_COUNT, 16'h0);
            run_for(base, 5);
            cap_in = 2'b11; idle(1);
            cap_in = 2'b00; idle(1);
            rd(AD_STAT, rv); chk(rv[3:0], 4'hF, "R3 R2 all flags raised");
            wr(AD_STAT, {12'h0, keep});
            wr(AD_CTRL, mk_ctrl(0, 0, gc, gm, 1, 1));
            wr(AD_IEN, {8'h0, ie, 4'h0});
            ec = exp_irq(gc, ie[3], ie[1], keep[0], keep[1]);
            em = exp_irq(gm, ie[2], ie[0], keep[2], keep[3]);
            chk(cap_irq, ec, gc ? "R6 R5 capture request" :
                              (ie[3] | ie[1]) ? "R7 R5 capture request" : "R8 capture request");
            chk(cmp_irq, em, gm ? "R6 R5 compare request" :
                              (ie[2] | ie[0]) ? "R7 R5 compare request" : "R8 compare request");
        end
        wr(AD_IEN, 16'h0);

        // R9..R11 PWM mode
        pwm_case(3, 9);
        wr(AD_IEN, 16'h0040);
        chk(cmp_irq, 1'b0, "R7 PWM compare-1 enable only");
        wr(AD_IEN, 16'h0010);
        chk(cmp_irq, 1'b1, "R10 R7 PWM compare-2 enable");
        wr(AD_IEN, 16'h0000);
        wr(AD_CTRL, mk_ctrl(0, 1, 0, 1, 1, 1));
        chk(cmp_irq, 1'b1, "R6 PWM global compare enable");
        wr(AD_STAT, 16'h0);
        wr(AD_CTRL, mk_ctrl(1, 1, 0, 0, 1, 1));
        idle(12);
        wr(AD_CTRL, mk_ctrl(0, 1, 0, 0, 1, 1));
        rd(AD_STAT, rv); chk(rv[3], 1'b1, "R10 flag set again each period");
        pwm_case(6, 6);
        pwm_case(0, 1);
        for (int it = 0; it < 4; it++) begin
            int c1, c2;
            c1 = $urandom_range(0, 5);
            c2 = $urandom_range(c1 + 1, 12);
            pwm_case(c1, c2);
        end
        wr(AD_CTRL, base);
        idle(1);
        chk(pwm_out, 1'b0, "R11 low outside PWM mode");

        finish_run();
    end
endmodule